// File: doc/BRIEF.md
# Fetch Address Sequencing Unit

This block sits at the head of an instruction fetch stage. It keeps a small window of three program-counter slots: the address fetched last, the address being fetched now, and the address that follows it. Each slot has its own valid flag. The current slot is offered to the fetch side over a valid/ack handshake. With it go an enable bit for each instruction position in the fetch bundle, a bundle pointer, a two-bit branch state and a prediction identifier.

A second handshake asks a branch predictor where fetch goes after the current address. The block shows the predictor the previous and current addresses and a flag that says the current address is a taken delay slot. The predictor's answer fills the next slot, or the current slot when that slot is empty. A third handshake carries a redirect event that restarts fetch at a new address. The redirect can always be accepted.

All three handshakes may complete in the same cycle. Their updates are applied in a fixed order: fetch first, then prediction, then redirect. A redirect therefore wins over the other two.

Top module: `fasu_top`

## Requirements
- R1: After active-low reset, `fetch_valid` and `pred_valid` are 0 and `evt_ack` is 1. `evt_ack` stays 1 at all times.
- R2: `fetch_addr`, `fetch_en`, `fetch_ptr`, `fetch_bst` and `fetch_pid` carry the fields of the current slot whenever `fetch_valid` is 1.
- R3: A completed fetch transaction (`fetch_valid` and `fetch_ack` both 1) has these effects:
  - The previous slot takes the current address and becomes valid.
  - If the next slot was valid, the current slot takes all of its fields and stays valid. Otherwise the current slot becomes invalid.
  - The next slot becomes invalid.
- R4: While `pred_valid` is 1, `pred_prev_pc` shows the previous address, `pred_cur_pc` shows the current address and `pred_cur_ds` shows the current slot's delay-slot flag.
- R5: A completed predict transaction writes `pred_next_pc`, `pred_next_ds`, `pred_en`, `pred_ptr`, `pred_bst` and `pred_pid` into one slot:
  - into the next slot, which becomes valid, if the current slot is valid after the fetch update of the same cycle;
  - otherwise into the current slot, which becomes valid.
- R6: A completed event (`evt_valid` with `evt_ack`) has these effects:
  - The current address is loaded from `evt_addr`.
  - The current slot becomes valid and the next slot becomes invalid.
  - The bundle pointer, the prediction identifier and the delay-slot flag are cleared.
  - Branch state is set to 0, which means "none".
  - The enable vector is set to 1, so that only instruction position 0 is enabled.
- R7: Within one cycle, the fetch update is applied first, then the predict update, then the event update. An event in the same cycle overrides the slot writes of the other two.
- R8: `pred_valid` is 1 exactly when either of these holds, so that no prediction can be lost:
  - the current slot is valid and the next slot is empty;
  - the current slot is empty and the previous slot is valid.
- R9: `fetch_valid` is 1 exactly when the current slot is valid.
- R10: Addresses are stored word aligned: bits [1:0] of every address loaded from `evt_addr` or `pred_next_pc` are stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | output | 1 | Current slot offered to the fetch side |
| fetch_ack | input | 1 | Fetch side takes the current slot |
| fetch_addr | output | AW | Current fetch address |
| fetch_en | output | NI | Enable bit for each instruction position |
| fetch_ptr | output | PTR_W | Bundle pointer of the current slot |
| fetch_bst | output | 2 | Branch state of the current slot |
| fetch_pid | output | IDW | Prediction identifier of the current slot |
| pred_valid | output | 1 | Request to the predictor |
| pred_ack | input | 1 | Predictor answers this cycle |
| pred_prev_pc | output | AW | Previous address |
| pred_cur_pc | output | AW | Current address |
| pred_cur_ds | output | 1 | Current slot is a taken delay slot |
| pred_next_pc | input | AW | Predicted following address |
| pred_next_ds | input | 1 | Following address is a taken delay slot |
| pred_en | input | NI | Enable vector for the following address |
| pred_ptr | input | PTR_W | Bundle pointer for the following address |
| pred_bst | input | 2 | Branch state for the following address |
| pred_pid | input | IDW | Prediction identifier for the following address |
| evt_valid | input | 1 | Redirect request |
| evt_ack | output | 1 | Redirect accepted |
| evt_addr | input | AW | Redirect target address |

## Verification
All outputs are decoded from the slot registers without further registers. A transaction that completes at one rising edge therefore shows its effect on every output during the very next clock period.

The driver sets the inputs just after a rising edge. It then computes, from its own slot model, the output values for that period and queues them. The monitor pops the queued item at the falling edge of the same period and compares it with the outputs. Field outputs are compared only while the matching valid output is high.

// File: rtl/fasu_pkg.sv
package fasu_pkg;

  localparam int BST_W = 2;
  localparam logic [BST_W-1:0] BST_NONE = 2'd0;

  typedef enum logic [1:0] {
    CUR_HOLD      = 2'd0,
    CUR_FROM_NEXT = 2'd1,
    CUR_FROM_PRED = 2'd2,
    CUR_FROM_EVT  = 2'd3
  } cur_sel_e;

  // Predictor request rule: room for an answer exists, or a restart after drain
  function automatic logic pred_may_issue(input logic p_v, input logic c_v, input logic n_v);
    return (c_v && !n_v) || (!c_v && p_v);
  endfunction

endpackage

// File: rtl/fasu_ctrl.sv
module fasu_ctrl
  import fasu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fetch_ack,
  input  logic     pred_ack,
  input  logic     evt_valid,
  output logic     p_val,
  output logic     c_val,
  output logic     n_val,
  output logic     fetch_fire,
  output logic     pred_fire,
  output logic     evt_fire,
  output cur_sel_e cur_sel,
  output logic     nxt_load
);

  logic c_after_fetch, n_after_fetch;
  logic c_nx, n_nx, p_nx;

  assign fetch_fire = c_val && fetch_ack;
  assign pred_fire  = pred_may_issue(p_val, c_val, n_val) && pred_ack;
  assign evt_fire   = evt_valid;

  always_comb begin
    // step 1: fetch
    c_after_fetch = fetch_fire ? n_val : c_val;
    n_after_fetch = fetch_fire ? 1'b0  : n_val;
    cur_sel       = (fetch_fire && n_val) ? CUR_FROM_NEXT : CUR_HOLD;
    nxt_load      = 1'b0;
    c_nx          = c_after_fetch;
    n_nx          = n_after_fetch;
    // step 2: predict
    if (pred_fire) begin
      if (c_after_fetch) begin
        n_nx     = 1'b1;
        nxt_load = 1'b1;
      end else begin
        c_nx    = 1'b1;
        cur_sel = CUR_FROM_PRED;
      end
    end
    // step 3: event
    if (evt_fire) begin
      c_nx     = 1'b1;
      n_nx     = 1'b0;
      cur_sel  = CUR_FROM_EVT;
      nxt_load = 1'b0;
    end
    p_nx = p_val || fetch_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_val <= 1'b0;
      c_val <= 1'b0;
      n_val <= 1'b0;
    end else begin
      p_val <= p_nx;
      c_val <= c_nx;
      n_val <= n_nx;
    end
  end

endmodule

// File: rtl/fasu_slot.sv
module fasu_slot #(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST;
    else if (load) q <= d;
  end

endmodule

// File: rtl/fasu_top.sv
module fasu_top
  import fasu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int NI       = 4,
  parameter int PTR_W    = 2,
  parameter int IDW      = 3,
  parameter logic [AW-1:0] RESET_PC = 'h100
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             fetch_valid,
  input  logic             fetch_ack,
  output logic [AW-1:0]    fetch_addr,
  output logic [NI-1:0]    fetch_en,
  output logic [PTR_W-1:0] fetch_ptr,
  output logic [BST_W-1:0] fetch_bst,
  output logic [IDW-1:0]   fetch_pid,
  output logic             pred_valid,
  input  logic             pred_ack,
  output logic [AW-1:0]    pred_prev_pc,
  output logic [AW-1:0]    pred_cur_pc,
  output logic             pred_cur_ds,
  input  logic [AW-1:0]    pred_next_pc,
  input  logic             pred_next_ds,
  input  logic [NI-1:0]    pred_en,
  input  logic [PTR_W-1:0] pred_ptr,
  input  logic [BST_W-1:0] pred_bst,
  input  logic [IDW-1:0]   pred_pid,
  input  logic             evt_valid,
  output logic             evt_ack,
  input  logic [AW-1:0]    evt_addr
);

  localparam int SLOT_W = AW + NI + PTR_W + BST_W + IDW + 1;
  localparam int EN_LO  = AW;
  localparam int PTR_LO = EN_LO + NI;
  localparam int BST_LO = PTR_LO + PTR_W;
  localparam int PID_LO = BST_LO + BST_W;
  localparam int DS_BIT = PID_LO + IDW;
  localparam logic [NI-1:0] EN_FIRST = NI'(1);

  function automatic logic [AW-1:0] word_align(input logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction

  localparam logic [SLOT_W-1:0] SLOT_RST =
    {1'b0, {IDW{1'b0}}, BST_NONE, {PTR_W{1'b0}}, EN_FIRST, {RESET_PC[AW-1:2], 2'b00}};

  logic p_val, c_val, n_val;
  logic fetch_fire, pred_fire, evt_fire, nxt_load;
  cur_sel_e cur_sel;

  logic [SLOT_W-1:0] cur_q, nxt_q, cur_d, pred_word, evt_word;
  logic [AW-1:0]     prev_q;

  fasu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fetch_ack(fetch_ack), .pred_ack(pred_ack), .evt_valid(evt_valid),
    .p_val(p_val), .c_val(c_val), .n_val(n_val),
    .fetch_fire(fetch_fire), .pred_fire(pred_fire), .evt_fire(evt_fire),
    .cur_sel(cur_sel), .nxt_load(nxt_load)
  );

  assign pred_word = {pred_next_ds, pred_pid, pred_bst, pred_ptr, pred_en, word_align(pred_next_pc)};
  assign evt_word  = {1'b0, {IDW{1'b0}}, BST_NONE, {PTR_W{1'b0}}, EN_FIRST, word_align(evt_addr)};

  always_comb begin
    case (cur_sel)
      CUR_FROM_NEXT: cur_d = nxt_q;
      CUR_FROM_PRED: cur_d = pred_word;
      CUR_FROM_EVT:  cur_d = evt_word;
      default:       cur_d = cur_q;
    endcase
  end

  fasu_slot #(.W(SLOT_W), .RST(SLOT_RST)) u_cur (
    .clk(clk), .rst_n(rst_n), .load(cur_sel != CUR_HOLD), .d(cur_d), .q(cur_q)
  );

  fasu_slot #(.W(SLOT_W), .RST(SLOT_RST)) u_nxt (
    .clk(clk), .rst_n(rst_n), .load(nxt_load), .d(pred_word), .q(nxt_q)
  );

  fasu_slot #(.W(AW), .RST({RESET_PC[AW-1:2], 2'b00})) u_prev (
    .clk(clk), .rst_n(rst_n), .load(fetch_fire), .d(cur_q[AW-1:0]), .q(prev_q)
  );

  assign fetch_valid  = c_val;
  assign fetch_addr   = cur_q[AW-1:0];
  assign fetch_en     = cur_q[EN_LO +: NI];
  assign fetch_ptr    = cur_q[PTR_LO +: PTR_W];
  assign fetch_bst    = cur_q[BST_LO +: BST_W];
  assign fetch_pid    = cur_q[PID_LO +: IDW];
  assign pred_valid   = pred_may_issue(p_val, c_val, n_val);
  assign pred_prev_pc = prev_q;
  assign pred_cur_pc  = cur_q[AW-1:0];
  assign pred_cur_ds  = cur_q[DS_BIT];
  assign evt_ack      = 1'b1;

endmodule

// File: rtl/fasu_checker.sv
module fasu_checker #(
  parameter int AW = 32,
  parameter int NI = 4,
  parameter int PTR_W = 2,
  parameter int IDW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic             fetch_ack,
  input logic [AW-1:0]    fetch_addr,
  input logic [NI-1:0]    fetch_en,
  input logic [PTR_W-1:0] fetch_ptr,
  input logic [1:0]       fetch_bst,
  input logic             pred_valid,
  input logic             pred_ack,
  input logic [AW-1:0]    pred_prev_pc,
  input logic [AW-1:0]    pred_next_pc,
  input logic             evt_valid,
  input logic             evt_ack,
  input logic [AW-1:0]    evt_addr
);

  assert_evt_ack_high_R1: assert property (@(posedge clk) disable iff (!rst_n) evt_ack);

  assert_evt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_ack |=> fetch_valid && fetch_en == NI'(1) && fetch_ptr == '0 && fetch_bst == 2'd0
      && fetch_addr == {$past(evt_addr[AW-1:2]), 2'b00});

  assert_prev_takes_cur_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ack |=> pred_prev_pc == $past(fetch_addr));

  assert_pred_into_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && pred_ack && fetch_valid && !fetch_ack && !evt_valid |=> fetch_valid && $stable(fetch_addr) && !pred_valid);

  assert_pred_into_cur_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && pred_ack && !fetch_valid && !evt_valid |=> fetch_valid && fetch_addr == {$past(pred_next_pc[AW-1:2]), 2'b00});

  assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> fetch_addr[1:0] == 2'b00);

endmodule

bind fasu_top fasu_checker #(.AW(AW), .NI(NI), .PTR_W(PTR_W), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ack(fetch_ack),
  .fetch_addr(fetch_addr), .fetch_en(fetch_en), .fetch_ptr(fetch_ptr), .fetch_bst(fetch_bst),
  .pred_valid(pred_valid), .pred_ack(pred_ack), .pred_prev_pc(pred_prev_pc),
  .pred_next_pc(pred_next_pc), .evt_valid(evt_valid), .evt_ack(evt_ack), .evt_addr(evt_addr)
);

// File: tb/fasu_top_tb.sv
`timescale 1ns/1ps
module fasu_top_tb;

  localparam int AW = 32, NI = 4, PW = 2, IDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic fetch_valid, fetch_ack, pred_valid, pred_ack, pred_cur_ds, pred_next_ds;
  logic evt_valid, evt_ack;
  logic [AW-1:0] fetch_addr, pred_prev_pc, pred_cur_pc, pred_next_pc, evt_addr;
  logic [NI-1:0] fetch_en, pred_en;
  logic [PW-1:0] fetch_ptr, pred_ptr;
  logic [1:0] fetch_bst, pred_bst;
  logic [IDW-1:0] fetch_pid, pred_pid;

  fasu_top #(.AW(AW), .NI(NI), .PTR_W(PW), .IDW(IDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ack(fetch_ack),
    .fetch_addr(fetch_addr), .fetch_en(fetch_en), .fetch_ptr(fetch_ptr), .fetch_bst(fetch_bst),
    .fetch_pid(fetch_pid), .pred_valid(pred_valid), .pred_ack(pred_ack),
    .pred_prev_pc(pred_prev_pc), .pred_cur_pc(pred_cur_pc), .pred_cur_ds(pred_cur_ds),
    .pred_next_pc(pred_next_pc), .pred_next_ds(pred_next_ds), .pred_en(pred_en),
    .pred_ptr(pred_ptr), .pred_bst(pred_bst), .pred_pid(pred_pid),
    .evt_valid(evt_valid), .evt_ack(evt_ack), .evt_addr(evt_addr)
  );

  typedef struct {
    logic [AW-1:0] addr; logic [NI-1:0] en; logic [PW-1:0] ptr;
    logic [1:0] bst; logic [IDW-1:0] pid; logic ds;
  } slot_t;

  typedef struct {
    string tag; logic fv; logic pv;
    slot_t cur; logic [AW-1:0] prev;
  } exp_t;

  exp_t  sb[$];
  int    n_chk = 0, n_fail = 0;
  logic  mp_v, mc_v, mn_v;
  logic [AW-1:0] mp;
  slot_t mc, mn;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic model_pv();
    return (mc_v && !mn_v) || (!mc_v && mp_v);
  endfunction

  // driver: apply one cycle of inputs, queue expected outputs, advance model
  task automatic step(string tag, logic fa, logic pa, logic ev, logic [AW-1:0] ea,
                      logic [AW-1:0] pn, logic pds, logic [NI-1:0] pe, logic [PW-1:0] pp,
                      logic [1:0] pb, logic [IDW-1:0] pi);
    exp_t e;
    logic ffire, pfire;
    slot_t ps;
    @(posedge clk); #2;
    fetch_ack = fa; pred_ack = pa; evt_valid = ev; evt_addr = ea;
    pred_next_pc = pn; pred_next_ds = pds; pred_en = pe; pred_ptr = pp; pred_bst = pb; pred_pid = pi;
    e.tag = tag; e.fv = mc_v; e.pv = model_pv(); e.cur = mc; e.prev = mp;
    sb.push_back(e);
    ffire = mc_v && fa;
    pfire = model_pv() && pa;
    ps.addr = pn & ~32'h3; ps.en = pe; ps.ptr = pp; ps.bst = pb; ps.pid = pi; ps.ds = pds;
    if (ffire) begin
      mp = mc.addr; mp_v = 1'b1;
      mc_v = mn_v;
      if (mn_v) mc = mn;
      mn_v = 1'b0;
    end
    if (pfire) begin
      if (mc_v) begin mn = ps; mn_v = 1'b1; end
      else      begin mc = ps; mc_v = 1'b1; end
    end
    if (ev) begin
      mc_v = 1'b1; mn_v = 1'b0;
      mc.addr = ea & ~32'h3; mc.en = 4'b0001; mc.ptr = '0; mc.bst = 2'd0; mc.pid = '0; mc.ds = 1'b0;
    end
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor: compare queued expectation at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk("R9", {e.tag, " fetch_valid"}, 64'(fetch_valid), 64'(e.fv));
        chk("R8", {e.tag, " pred_valid"}, 64'(pred_valid), 64'(e.pv));
        chk("R1", {e.tag, " evt_ack"}, 64'(evt_ack), 64'd1);
        if (e.fv) begin
          chk("R2", {e.tag, " fetch_addr"}, 64'(fetch_addr), 64'(e.cur.addr));
          chk("R2", {e.tag, " fetch_en"},   64'(fetch_en),   64'(e.cur.en));
          chk("R2", {e.tag, " fetch_ptr"},  64'(fetch_ptr),  64'(e.cur.ptr));
          chk("R2", {e.tag, " fetch_bst"},  64'(fetch_bst),  64'(e.cur.bst));
          chk("R2", {e.tag, " fetch_pid"},  64'(fetch_pid),  64'(e.cur.pid));
        end
        if (e.pv) begin
          chk("R4", {e.tag, " pred_prev_pc"}, 64'(pred_prev_pc), 64'(e.prev));
          chk("R4", {e.tag, " pred_cur_pc"},  64'(pred_cur_pc),  64'(e.cur.addr));
          chk("R4", {e.tag, " pred_cur_ds"},  64'(pred_cur_ds),  64'(e.cur.ds));
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    fetch_ack = 0; pred_ack = 0; evt_valid = 0; evt_addr = 0; pred_next_pc = 0;
    pred_next_ds = 0; pred_en = 0; pred_ptr = 0; pred_bst = 0; pred_pid = 0;
    mp_v = 0; mc_v = 0; mn_v = 0; mp = 32'h100;
    mc.addr = 32'h100; mc.en = 4'b0001; mc.ptr = 0; mc.bst = 0; mc.pid = 0; mc.ds = 0;
    mn = mc;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset fetch_valid", 64'(fetch_valid), 64'd0);
    chk("R1", "reset pred_valid", 64'(pred_valid), 64'd0);
    chk("R1", "reset evt_ack", 64'(evt_ack), 64'd1);

    // R6: redirect start with unaligned target (R10)
    step("R6", 0, 0, 1, 32'h0000_0203, 0, 0, 0, 0, 0, 0);
    // R5: current valid, next free -> prediction into next
    step("R5", 0, 1, 0, 0, 32'h0000_0404, 1, 4'b0110, 2'd1, 2'd2, 3'd5);
    idle("R5");
    // R3: fetch with next valid moves next to current
    step("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3: fetch with next empty drains current; then predict fills current
    step("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 1, 0, 0, 32'h0000_0817, 0, 4'b1100, 2'd3, 2'd1, 3'd2);
    idle("R10");
    // R7: fetch + predict together; then all three together
    step("R7", 1, 1, 0, 0, 32'h0000_0a00, 1, 4'b0011, 2'd2, 2'd3, 3'd7);
    step("R7", 1, 1, 1, 32'h0000_3000, 32'h0000_0b00, 1, 4'b1111, 2'd1, 2'd1, 3'd1);
    idle("R7");

    for (int i = 0; i < 3000; i++)
      step("R7", ($urandom % 100) < 70, ($urandom % 100) < 70, ($urandom % 100) < 8,
           $urandom, $urandom, 1'($urandom), 4'($urandom), 2'($urandom), 2'($urandom), 3'($urandom));
    idle("R2");
    @(posedge clk);
    @(negedge clk); #1;
    chk("R2", "scoreboard drained", 64'(sb.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule